// File: doc/BRIEF.md
# Retention-Aware Refresh Bin Scheduler

This block sits in a memory controller and decides, once per refresh interval, what refresh command goes to the memory device. The device's row space is divided into refresh bins, where one bin is the set of rows one default refresh covers. Each bin is divided into four quarter bins. A table holds a 2-bit retention class for every quarter bin. Class c means the quarter keeps its data for c+1 retention rounds. A round counter counts retention periods. For each position the block issues either a real refresh or a dummy refresh. A dummy refresh only advances the device's internal row counter. Weak regions are therefore refreshed every round, and strong regions are only refreshed in the rounds when they are due.

The block keeps a local copy of the device counter as a bin pointer, a quarter pointer and a round count. Software or a resynchronisation engine can overwrite this copy, for example after the device leaves a low-power state and its counter has been read back. In coarse mode the block issues one full-bin command per bin. In fine mode it works in quarters. In fine mode a bin with no due quarter is still skipped with a single full-bin dummy. Interval ticks are banked as owed decisions. Each owed decision is presented as a strobe with a type code and is held until the command bus grants it. The profiling that fills the table is done elsewhere.

Top module: `rfsh_bin_sched`

## Requirements
- R1: After reset no command is offered, the pointer is at bin 0 quarter 0, the round is 0, and every table entry holds class 0.
- R2: Each tick adds one owed decision and each grant (valid and ready) consumes one. `cmd_valid_o` is high exactly while decisions are owed. The owed count saturates at OWE_MAX (default 8), so further ticks are lost.
- R3: Type codes are 0 = full-bin refresh, 1 = full-bin dummy, 2 = quarter refresh, 3 = quarter dummy. Full-bin codes only appear with the quarter pointer at 0.
- R4: A quarter of class c is due when round mod (c+1) equals 0. The round count runs 0 to 11 and then wraps to 0.
- R5: In coarse mode at quarter 0, the block issues type 0 if any quarter of the bin is due and type 1 otherwise. A grant advances the pointer by one bin. For example, with bins of classes 0,1,0,1 in round 1 the sequence is refresh, dummy, refresh, dummy.
- R6: In fine mode at quarter 0, a bin with no due quarter receives a single type 1 that skips the whole bin.
- R7: In all other cases (fine mode, or the quarter pointer not at 0), the block issues type 2 if the current quarter is due and type 3 if not. A grant advances the pointer by one quarter, and after quarter 3 it moves on to the next bin.
- R8: The round count increments exactly when the bin pointer wraps from NUM_BINS-1 to 0 through a grant. At all other times it is held.
- R9: A sync pulse loads the bin pointer, sets the quarter to 0 and loads the round. A round value of 12 or more is reduced by 12. Sync takes priority over a grant in the same cycle.
- R10: While a command is offered and not granted, and no sync arrives, the offered bin and quarter stay unchanged.
- R11: A table write at address bin*4+quarter sets that quarter's class.
- R12: A bin whose quarters are all class 0 is refreshed in every round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Refresh interval pulse |
| fine_mode_i | input | 1 | 1 selects quarter granularity |
| tbl_we_i | input | 1 | Class table write enable |
| tbl_addr_i | input | BIN_W+2 | Quarter address, bin*4+quarter |
| tbl_class_i | input | 2 | Class to write |
| sync_i | input | 1 | Load the local counter copy |
| sync_bin_i | input | BIN_W | Bin value to load |
| sync_round_i | input | 4 | Round value to load |
| cmd_ready_i | input | 1 | Command bus grant |
| cmd_valid_o | output | 1 | Decision offered |
| cmd_type_o | output | 2 | Decision type code |
| cmd_bin_o | output | BIN_W | Bin the decision targets |
| cmd_quarter_o | output | 2 | Quarter the decision targets |
| round_o | output | 4 | Current round count |

## Verification
The bench targets mixed-class bins whose due quarters change from round to round. A design that took the weakest class instead of checking each quarter would skip refreshes of class-2 quarters in round 3. It also targets fine mode across an all-strong bin. A design that lacked the full-bin skip would issue four quarter dummies where one full-bin dummy belongs. Other cases covered are the round wrap at twelve and a sync with an out-of-range round. A design that got the modulus wrong would drift out of phase with the classes, so every later decision would be wrong. Finally, the bench checks owed-decision saturation and holding a command under backpressure. A design that got these wrong would either lose or duplicate refreshes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    CMD_REF_BIN   = 2'd0,
    CMD_SKIP_BIN  = 2'd1,
    CMD_REF_QTR   = 2'd2,
    CMD_SKIP_QTR  = 2'd3
  } rfsh_cmd_e;

  localparam int unsigned ROUND_PERIOD = 12;
  localparam int unsigned QTR_PER_BIN  = 4;

  // True when a region of the given class needs a real refresh this round.
  function automatic logic class_due(input logic [1:0] cls, input logic [3:0] rnd);
    logic due;
    case (cls)
      2'd0:    due = 1'b1;
      2'd1:    due = ~rnd[0];
      2'd2:    due = (rnd == 4'd0) || (rnd == 4'd3) || (rnd == 4'd6) || (rnd == 4'd9);
      default: due = (rnd[1:0] == 2'b00);
    endcase
    return due;
  endfunction
endpackage

// File: rtl/rfsh_class_table.sv
module rfsh_class_table #(
  parameter int unsigned NUM_BINS = 16,
  localparam int unsigned BIN_W   = $clog2(NUM_BINS),
  localparam int unsigned ADDR_W  = BIN_W + 2,
  localparam int unsigned DEPTH   = NUM_BINS * rfsh_pkg::QTR_PER_BIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [1:0]        wr_class_i,
  input  logic [BIN_W-1:0]  rd_bin_i,
  output logic [7:0]        rd_classes_o
);
  logic [1:0] cls_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cls_q[i] <= 2'd0;
    end else if (wr_en_i) begin
      cls_q[wr_addr_i] <= wr_class_i;
    end
  end

  for (genvar q = 0; q < 4; q++) begin : g_rd
    assign rd_classes_o[2*q +: 2] = cls_q[{rd_bin_i, 2'(q)}];
  end
endmodule

// File: rtl/rfsh_decide.sv
module rfsh_decide
  import rfsh_pkg::*;
(
  input  logic [7:0] classes_i,
  input  logic [3:0] round_i,
  input  logic [1:0] quarter_i,
  input  logic       fine_i,
  output rfsh_cmd_e  cmd_o
);
  logic [3:0] qtr_due;
  logic       any_due;
  logic       per_qtr;

  for (genvar q = 0; q < 4; q++) begin : g_due
    assign qtr_due[q] = class_due(classes_i[2*q +: 2], round_i);
  end

  assign any_due = |qtr_due;
  assign per_qtr = fine_i || (quarter_i != 2'd0);

  always_comb begin
    if (!per_qtr) begin
      cmd_o = any_due ? CMD_REF_BIN : CMD_SKIP_BIN;
    end else if ((quarter_i == 2'd0) && !any_due) begin
      cmd_o = CMD_SKIP_BIN;
    end else begin
      cmd_o = qtr_due[quarter_i] ? CMD_REF_QTR : CMD_SKIP_QTR;
    end
  end
endmodule

// File: rtl/rfsh_position.sv
module rfsh_position #(
  parameter int unsigned NUM_BINS = 16,
  localparam int unsigned BIN_W   = $clog2(NUM_BINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [BIN_W-1:0] sync_bin_i,
  input  logic [3:0]       sync_round_i,
  input  logic             step_bin_i,
  input  logic             step_qtr_i,
  output logic [BIN_W-1:0] bin_o,
  output logic [1:0]       quarter_o,
  output logic [3:0]       round_o
);
  localparam logic [BIN_W-1:0] LAST_BIN   = BIN_W'(NUM_BINS - 1);
  localparam logic [3:0]       LAST_ROUND = 4'(rfsh_pkg::ROUND_PERIOD - 1);

  logic [BIN_W-1:0] bin_q, bin_d;
  logic [1:0]       qtr_q, qtr_d;
  logic [3:0]       rnd_q, rnd_d;
  logic             bin_adv;

  always_comb begin
    bin_d   = bin_q;
    qtr_d   = qtr_q;
    rnd_d   = rnd_q;
    bin_adv = 1'b0;
    if (sync_i) begin
      bin_d = sync_bin_i;
      qtr_d = 2'd0;
      rnd_d = (sync_round_i > LAST_ROUND) ? (sync_round_i - 4'(rfsh_pkg::ROUND_PERIOD))
                                          : sync_round_i;
    end else if (step_bin_i) begin
      qtr_d   = 2'd0;
      bin_adv = 1'b1;
    end else if (step_qtr_i) begin
      qtr_d   = qtr_q + 2'd1;
      bin_adv = (qtr_q == 2'd3);
    end
    if (bin_adv) begin
      if (bin_q == LAST_BIN) begin
        bin_d = '0;
        rnd_d = (rnd_q == LAST_ROUND) ? 4'd0 : rnd_q + 4'd1;
      end else begin
        bin_d = bin_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      qtr_q <= 2'd0;
      rnd_q <= 4'd0;
    end else begin
      bin_q <= bin_d;
      qtr_q <= qtr_d;
      rnd_q <= rnd_d;
    end
  end

  assign bin_o     = bin_q;
  assign quarter_o = qtr_q;
  assign round_o   = rnd_q;
endmodule

// File: rtl/rfsh_owed.sv
module rfsh_owed #(
  parameter int unsigned OWE_MAX = 8,
  localparam int unsigned CNT_W  = $clog2(OWE_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic grant_i,
  output logic pending_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(OWE_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (tick_i && !grant_i && (cnt_q != CAP)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (!tick_i && grant_i) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pending_o = (cnt_q != '0);
endmodule

// File: rtl/rfsh_bin_sched.sv
module rfsh_bin_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned NUM_BINS = 16,
  parameter int unsigned OWE_MAX  = 8,
  localparam int unsigned BIN_W   = $clog2(NUM_BINS),
  localparam int unsigned ADDR_W  = BIN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              fine_mode_i,
  input  logic              tbl_we_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [1:0]        tbl_class_i,
  input  logic              sync_i,
  input  logic [BIN_W-1:0]  sync_bin_i,
  input  logic [3:0]        sync_round_i,
  input  logic              cmd_ready_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_type_o,
  output logic [BIN_W-1:0]  cmd_bin_o,
  output logic [1:0]        cmd_quarter_o,
  output logic [3:0]        round_o
);
  logic [BIN_W-1:0] cur_bin;
  logic [1:0]       cur_qtr;
  logic [3:0]       cur_rnd;
  logic [7:0]       bin_classes;
  rfsh_cmd_e        decision;
  logic             pending;
  logic             grant;

  rfsh_class_table #(.NUM_BINS(NUM_BINS)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (tbl_we_i),
    .wr_addr_i    (tbl_addr_i),
    .wr_class_i   (tbl_class_i),
    .rd_bin_i     (cur_bin),
    .rd_classes_o (bin_classes)
  );

  rfsh_decide u_decide (
    .classes_i (bin_classes),
    .round_i   (cur_rnd),
    .quarter_i (cur_qtr),
    .fine_i    (fine_mode_i),
    .cmd_o     (decision)
  );

  rfsh_owed #(.OWE_MAX(OWE_MAX)) u_owed (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .grant_i   (grant),
    .pending_o (pending)
  );

  assign grant = pending && cmd_ready_i;

  rfsh_position #(.NUM_BINS(NUM_BINS)) u_pos (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .sync_bin_i   (sync_bin_i),
    .sync_round_i (sync_round_i),
    .step_bin_i   (grant && !decision[1]),
    .step_qtr_i   (grant && decision[1]),
    .bin_o        (cur_bin),
    .quarter_o    (cur_qtr),
    .round_o      (cur_rnd)
  );

  assign cmd_valid_o   = pending;
  assign cmd_type_o    = decision;
  assign cmd_bin_o     = cur_bin;
  assign cmd_quarter_o = cur_qtr;
  assign round_o       = cur_rnd;
endmodule

// File: rtl/rfsh_bin_sched_chk.sv
module rfsh_bin_sched_chk #(
  parameter int unsigned NUM_BINS = 16,
  localparam int unsigned BIN_W   = $clog2(NUM_BINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             sync_i,
  input logic [BIN_W-1:0] sync_bin_i,
  input logic             cmd_ready_i,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_type_o,
  input logic [BIN_W-1:0] cmd_bin_o,
  input logic [1:0]       cmd_quarter_o,
  input logic [3:0]       round_o
);
  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NUM_BINS - 1);

  logic grant;
  assign grant = cmd_valid_o && cmd_ready_i;

  a_r2_tick_offers: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cmd_valid_o);

  a_r3_bin_cmd_at_q0: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_type_o[1]) |-> (cmd_quarter_o == 2'd0));

  a_r4_round_range: assert property (@(posedge clk) disable iff (!rst_n)
    round_o < 4'd12);

  a_r5_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !cmd_type_o[1] && !sync_i) |=>
      (cmd_quarter_o == 2'd0) &&
      (cmd_bin_o == (($past(cmd_bin_o) == LAST_BIN) ? BIN_W'(0) : $past(cmd_bin_o) + 1'b1)));

  a_r7_quarter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cmd_type_o[1] && !sync_i) |=> (cmd_quarter_o == $past(cmd_quarter_o) + 2'd1));

  a_r8_round_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !sync_i && (cmd_bin_o == LAST_BIN) && (!cmd_type_o[1] || (cmd_quarter_o == 2'd3))) |=>
      (round_o == (($past(round_o) == 4'd11) ? 4'd0 : $past(round_o) + 4'd1)));

  a_r8_round_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && !grant) |=> $stable(round_o));

  a_r9_sync_load: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> ((cmd_bin_o == $past(sync_bin_i)) && (cmd_quarter_o == 2'd0)));

  a_r10_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i && !sync_i) |=>
      (cmd_valid_o && $stable(cmd_bin_o) && $stable(cmd_quarter_o)));
endmodule

bind rfsh_bin_sched rfsh_bin_sched_chk #(.NUM_BINS(NUM_BINS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .sync_i        (sync_i),
  .sync_bin_i    (sync_bin_i),
  .cmd_ready_i   (cmd_ready_i),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_type_o    (cmd_type_o),
  .cmd_bin_o     (cmd_bin_o),
  .cmd_quarter_o (cmd_quarter_o),
  .round_o       (round_o)
);

// File: tb/tb_rfsh_bin_sched.sv
module tb_rfsh_bin_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick, fine, we, sync, ready;
  logic [BW+1:0] addr;
  logic [1:0]    wcls;
  logic [BW-1:0] sbin;
  logic [3:0]    srnd;
  logic          valid;
  logic [1:0]    ctype, cqtr;
  logic [BW-1:0] cbin;
  logic [3:0]    rnd;

  int checks = 0;
  int fails  = 0;

  int m_cls [NB*4];
  int m_bin, m_qtr, m_rnd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfsh_bin_sched #(.NUM_BINS(NB), .OWE_MAX(8)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .fine_mode_i(fine),
    .tbl_we_i(we), .tbl_addr_i(addr), .tbl_class_i(wcls),
    .sync_i(sync), .sync_bin_i(sbin), .sync_round_i(srnd),
    .cmd_ready_i(ready), .cmd_valid_o(valid), .cmd_type_o(ctype),
    .cmd_bin_o(cbin), .cmd_quarter_o(cqtr), .round_o(rnd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit m_due(input int c, input int r);
    return (r % (c + 1)) == 0;
  endfunction

  function automatic int m_type();
    bit any = 0;
    for (int q = 0; q < 4; q++) if (m_due(m_cls[m_bin*4+q], m_rnd)) any = 1;
    if (!fine && m_qtr == 0) return any ? 0 : 1;
    if (m_qtr == 0 && !any) return 1;
    return m_due(m_cls[m_bin*4+m_qtr], m_rnd) ? 2 : 3;
  endfunction

  task automatic m_next_bin();
    m_qtr = 0;
    if (m_bin == NB-1) begin
      m_bin = 0;
      m_rnd = (m_rnd + 1) % 12;
    end else m_bin++;
  endtask

  task automatic do_reset();
    tick = 0; fine = 0; we = 0; sync = 0; ready = 0;
    addr = '0; wcls = 0; sbin = '0; srnd = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NB*4; i++) m_cls[i] = 0;
    m_bin = 0; m_qtr = 0; m_rnd = 0;
  endtask

  task automatic wr(input int a, input int c);
    @(negedge clk);
    we = 1; addr = (BW+2)'(a); wcls = 2'(c);
    @(negedge clk);
    we = 0;
    m_cls[a] = c;
  endtask

  task automatic do_sync(input int b, input int r);
    @(negedge clk);
    sync = 1; sbin = BW'(b); srnd = 4'(r);
    @(negedge clk);
    sync = 0;
    m_bin = b; m_qtr = 0; m_rnd = r % 12;
  endtask

  // One interval: tick, compare offer with the model, grant it.
  task automatic step(input string req, output int got);
    int exp;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    exp = m_type();
    got = ctype;
    chk({req, " valid"}, valid, 1);
    chk({req, " type"}, ctype, exp);
    chk({req, " bin"}, cbin, m_bin);
    chk({req, " quarter"}, cqtr, m_qtr);
    ready = 1;
    @(negedge clk); ready = 0;
    if (exp < 2) m_next_bin();
    else begin
      m_qtr++;
      if (m_qtr == 4) m_next_bin();
    end
  endtask

  task automatic t_reset();
    int t;
    do_reset();
    chk("R1 no offer", valid, 0);
    chk("R1 bin", cbin, 0);
    chk("R1 quarter", cqtr, 0);
    chk("R1 round", rnd, 0);
    step("R1 class0 table", t);
    chk("R1 first refresh", t, 0);
  endtask

  task automatic t_all_weak();
    int t;
    do_reset();
    for (int i = 0; i < NB; i++) begin
      step("R12 weak bin", t);
      chk("R12 always refreshed", t, 0);
    end
    chk("R8 round after wrap", rnd, 1);
  endtask

  task automatic t_example();
    int t;
    int exp_seq [4] = '{0, 1, 0, 1};
    do_reset();
    for (int b = 0; b < 4; b++)
      for (int q = 0; q < 4; q++) wr(b*4+q, b % 2);
    do_sync(0, 1);
    for (int i = 0; i < 4; i++) begin
      step("R5 coarse", t);
      chk("R5 ref/dummy pattern", t, exp_seq[i]);
    end
  endtask

  task automatic t_fine();
    int t;
    int exp_seq [5] = '{3, 3, 2, 3, 1};
    do_reset();
    wr(4*4+0, 3); wr(4*4+1, 3); wr(4*4+2, 0); wr(4*4+3, 3);
    for (int q = 0; q < 4; q++) wr(5*4+q, 3);
    fine = 1;
    do_sync(4, 1);
    for (int i = 0; i < 5; i++) begin
      step("R7 R11 fine", t);
      chk("R6 R7 fine pattern", t, exp_seq[i]);
    end
    chk("R6 skipped whole bin", cbin, 6);
    chk("R6 quarter reset", cqtr, 0);
    fine = 0;
  endtask

  task automatic t_sync();
    do_reset();
    do_sync(9, 14);
    chk("R9 bin loaded", cbin, 9);
    chk("R9 round reduced", rnd, 2);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    ready = 1; sync = 1; sbin = BW'(3); srnd = 4'd5;
    @(negedge clk); ready = 0; sync = 0;
    m_bin = 3; m_qtr = 0; m_rnd = 5;
    chk("R9 sync beats grant", cbin, 3);
    chk("R9 round", rnd, 5);
  endtask

  task automatic t_saturate();
    int n = 0;
    do_reset();
    repeat (10) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
    ready = 1;
    repeat (20) begin
      if (valid) n++;
      @(negedge clk);
    end
    ready = 0;
    chk("R2 owed capped", n, 8);
    chk("R2 drained", valid, 0);
  endtask

  task automatic t_hold();
    int b0, q0, t;
    do_reset();
    fine = 1;
    wr(0, 3);
    do_sync(0, 1);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    b0 = cbin; q0 = cqtr;
    repeat (3) begin
      @(negedge clk);
      chk("R10 held valid", valid, 1);
      chk("R10 held bin", cbin, b0);
      chk("R10 held quarter", cqtr, q0);
    end
    ready = 1;
    @(negedge clk); ready = 0;
    chk("R3 quarter dummy advanced", cqtr, 1);
    m_qtr = 1;
    step("R3 quarter code", t);
    chk("R3 quarter refresh code", t, 2);
    fine = 0;
  endtask

  task automatic t_sweep();
    int t;
    do_reset();
    for (int i = 0; i < NB*4; i++) wr(i, (i*7 + i/4) % 4);
    do_sync(0, 0);
    for (int i = 0; i < NB*12; i++) step("R4 coarse sweep", t);
    chk("R4 round wraps at 12", rnd, 0);
    fine = 1;
    while (m_rnd < 2) step("R4 R6 R7 fine sweep", t);
    fine = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_all_weak();
    t_example();
    t_fine();
    t_sync();
    t_saturate();
    t_hold();
    t_sweep();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule